// File: doc/BRIEF.md
# Configurable-Parity Serial Frame Transmitter

This block sends characters over a single asynchronous serial line. Software sets up the frame format through an 8-bit control and status register. The format can carry 7, 8 or 9 data bits. For 7- and 8-bit characters, a hardware-generated parity bit can be added. That bit can be odd, even, a constant 1 (mark) or a constant 0 (space). In 9-bit mode, one register bit is sent as the ninth data bit, and the same bit serves as a parity-type select in the other modes.

Characters are written through a separate transmit data port into a single-entry holding register. When the shifter is free, the holding register hands the character over. This lets software queue the next character while the current frame is still going out. Bit timing comes from an external baud-tick strobe, and each bit lasts a fixed number of ticks. The receive-full and error status bits are plain inputs, and the register port only reads them back.

Top module: `sertx_core`

## Requirements
- R1: After reset the register reads 0x01 (all control bits 0, transmit-empty 1) and `txd_o` is 1.
- R2: Register bits 7..3 are writable and read back as written: bit 7 enables parity, bit 6 is the high parity select, bit 5 is the shared ninth-bit / low parity select, and bits 4..3 are the length code. Bit 2 always reads `err_i` and bit 1 always reads `rx_full_i`. Writes to bits 2..0 have no effect.
- R3: Each frame is sent in this order: one 0 start bit, the data bits LSB first, the optional parity or ninth bit, and one 1 stop bit. Each bit lasts 16 baud ticks.
- R4: The length code selects the number of data bits: 00 gives 8, 01 gives 7, 10 gives 9, and 11 gives 8.
- R5: For 7- or 8-bit frames with bit 7 set, the select pair {bit 6, bit 5} = 00 adds odd parity and 01 adds even parity. Parity is computed over the data bits sent.
- R6: With parity enabled, select 10 always sends a 1 and select 11 always sends a 0 in the parity slot.
- R7: In 9-bit mode, bit 5 is sent as the ninth data bit, and bit 7 has no effect (no parity bit is added).
- R8: `tx_empty_o` and register bit 0 go to 0 on the cycle after a transmit write. They return to 1 in the cycle the character moves into the shifter.
- R9: A character written while a frame is shifting waits in the holding register. It is sent right after the current frame without being lost or altered.
- R10: `txd_o` is 1 whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control/status register read value |
| tx_we_i | input | 1 | Transmit data write strobe |
| tx_wdata_i | input | 8 | Transmit character (low 7 bits used in 7-bit mode) |
| baud_tick_i | input | 1 | Baud tick strobe, 16 per bit |
| err_i | input | 1 | Error status, read back at bit 2 |
| rx_full_i | input | 1 | Receive-full status, read back at bit 1 |
| txd_o | output | 1 | Serial output line |
| tx_empty_o | output | 1 | Holding register empty |

## Verification
The bench decodes every frame from the line at mid-bit and compares it with a frame it builds itself, across all four parity types, all four length codes, and a 9-bit character with both values of the shared bit. A design that swaps odd and even, counts parity over the unused eighth bit in 7-bit mode, or adds a parity bit in 9-bit mode would show up as a wrong bit or a wrong frame length. It also sends two characters back to back and checks that the second waits with the empty flag low. A holding register that drops or overwrites a character would lose a frame there. Status bits that software can write, or that do not follow their inputs, would fail the readback checks.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    LEN_8  = 2'b00,
    LEN_7  = 2'b01,
    LEN_9  = 2'b10,
    LEN_8B = 2'b11
  } len_e;

  typedef struct packed {
    logic par_en;
    logic psel_hi;
    logic xbit;
    len_e len;
  } cfg_t;
endpackage

// File: rtl/sertx_cfg_reg.sv
module sertx_cfg_reg
  import sertx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       err_i,
  input  logic       rx_full_i,
  input  logic       tx_empty_i,
  output cfg_t       cfg_o,
  output logic [7:0] rdata_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= cfg_t'(wdata_i[7:3]);
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {cfg_q, err_i, rx_full_i, tx_empty_i};
endmodule

// File: rtl/sertx_frame_build.sv
module sertx_frame_build
  import sertx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 3,
  parameter int NB_W    = $clog2(FRAME_W + 1)
) (
  input  cfg_t              cfg_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [NB_W-1:0]   nbits_o
);
  int unsigned       nd;
  logic              nine, has_extra, extra, par;
  logic [DATA_W-1:0] dm;

  always_comb begin
    nine = (cfg_i.len == LEN_9);
    nd   = (cfg_i.len == LEN_7) ? DATA_W - 1 : DATA_W;
    dm   = data_i;
    if (cfg_i.len == LEN_7) dm[DATA_W-1] = 1'b0;
    unique case ({cfg_i.psel_hi, cfg_i.xbit})
      2'b00:   par = ~^dm;
      2'b01:   par = ^dm;
      2'b10:   par = 1'b1;
      default: par = 1'b0;
    endcase
    has_extra = nine | cfg_i.par_en;
    extra     = nine ? cfg_i.xbit : par;
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < nd) frame_o[i+1] = dm[i];
    if (has_extra) frame_o[nd+1] = extra;
    nbits_o = NB_W'(nd + 2 + (has_extra ? 1 : 0));
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int DATA_W  = 8,
  parameter int TICKS   = 16,
  parameter int FRAME_W = DATA_W + 3,
  parameter int NB_W    = $clog2(FRAME_W + 1),
  localparam int CNT_W  = $clog2(TICKS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_we_i,
  input  logic [DATA_W-1:0]  tx_wdata_i,
  input  logic               tick_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [NB_W-1:0]    nbits_i,
  output logic [DATA_W-1:0]  hold_o,
  output logic               hold_valid_o,
  output logic               busy_o,
  output logic               txd_o
);
  logic [DATA_W-1:0]  hold_q;
  logic               hold_valid_q, busy_q, load;
  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [NB_W-1:0]    left_q;

  assign load = hold_valid_q & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q       <= '0;
      hold_valid_q <= 1'b0;
      busy_q       <= 1'b0;
      shift_q      <= '1;
      cnt_q        <= '0;
      left_q       <= '0;
    end else begin
      if (load) begin
        shift_q <= frame_i;
        left_q  <= nbits_i;
        busy_q  <= 1'b1;
        cnt_q   <= '0;
      end else if (busy_q && tick_i) begin
        if (cnt_q == CNT_W'(TICKS - 1)) begin
          cnt_q   <= '0;
          shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
          left_q  <= left_q - 1'b1;
          if (left_q == NB_W'(1)) busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (tx_we_i) begin
        hold_q       <= tx_wdata_i;
        hold_valid_q <= 1'b1;
      end else if (load) begin
        hold_valid_q <= 1'b0;
      end
    end
  end

  assign hold_o       = hold_q;
  assign hold_valid_o = hold_valid_q;
  assign busy_o       = busy_q;
  assign txd_o        = busy_q ? shift_q[0] : 1'b1;
endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TICKS  = 16,
  localparam int FRAME_W = DATA_W + 3,
  localparam int NB_W    = $clog2(FRAME_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              tx_we_i,
  input  logic [DATA_W-1:0] tx_wdata_i,
  input  logic              baud_tick_i,
  input  logic              err_i,
  input  logic              rx_full_i,
  output logic              txd_o,
  output logic              tx_empty_o
);
  cfg_t               cfg;
  logic [DATA_W-1:0]  hold;
  logic               hold_valid, busy;
  logic [FRAME_W-1:0] frame;
  logic [NB_W-1:0]    nbits;

  assign tx_empty_o = ~hold_valid;

  sertx_cfg_reg u_reg (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .err_i, .rx_full_i, .tx_empty_i(tx_empty_o),
    .cfg_o(cfg), .rdata_o(reg_rdata_o)
  );

  sertx_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .NB_W(NB_W)) u_build (
    .cfg_i(cfg), .data_i(hold), .frame_o(frame), .nbits_o(nbits)
  );

  sertx_shifter #(.DATA_W(DATA_W), .TICKS(TICKS), .FRAME_W(FRAME_W), .NB_W(NB_W)) u_shift (
    .clk_i, .rst_ni, .tx_we_i, .tx_wdata_i, .tick_i(baud_tick_i),
    .frame_i(frame), .nbits_i(nbits),
    .hold_o(hold), .hold_valid_o(hold_valid), .busy_o(busy), .txd_o
  );
endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       tx_we_i,
  input logic       txd_o,
  input logic       tx_empty_o,
  input logic       busy
);
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> txd_o); // R10
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !txd_o); // R3
  AST_EMPTY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_we_i |=> !tx_empty_o); // R8
  AST_LOAD_SETS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy) && !$past(tx_we_i)) |-> tx_empty_o); // R8
  AST_CFG_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o[7:3] == $past(reg_wdata_i[7:3])); // R2
  AST_EMPTY_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[0] == tx_empty_o); // R8
endmodule

bind sertx_core sertx_core_chk u_chk (
  .clk_i, .rst_ni, .reg_we_i, .reg_wdata_i, .reg_rdata_o,
  .tx_we_i, .txd_o, .tx_empty_o, .busy(busy)
);

// File: tb/sertx_core_test.sv
`timescale 1ns/1ps
module sertx_core_test;
  logic       clk = 0, rst_n = 0;
  logic       reg_we = 0, tx_we = 0, tick = 0, err = 0, rx_full = 0;
  logic [7:0] reg_wdata = 0, tx_wdata = 0, reg_rdata;
  logic       txd, tx_empty;
  int total = 0, bad = 0, cyc = 0;

  logic [15:0] exp_q[$];
  int          len_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  sertx_core uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .tx_we_i(tx_we), .tx_wdata_i(tx_wdata),
    .baud_tick_i(tick), .err_i(err), .rx_full_i(rx_full),
    .txd_o(txd), .tx_empty_o(tx_empty)
  );

  // baud tick on every other cycle
  always @(negedge clk) begin
    cyc++;
    tick <= cyc[0];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] v);
    @(negedge clk); reg_we = 1; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic tx_write(input logic [7:0] d);
    @(negedge clk); tx_we = 1; tx_wdata = d;
    @(negedge clk); tx_we = 0;
  endtask

  // expected frame, LSB = first bit on the line
  task automatic push_exp(input logic [7:0] cfg, input logic [7:0] d, input string tag);
    logic [15:0] f;
    int n, nd;
    logic [7:0] dm;
    bit pb;
    nd = (cfg[4:3] == 2'b01) ? 7 : (cfg[4:3] == 2'b10) ? 9 : 8;
    dm = (nd == 7) ? {1'b0, d[6:0]} : d;
    f = '1; n = 0;
    f[n++] = 1'b0;
    for (int i = 0; i < 8 && i < nd; i++) f[n++] = dm[i];
    if (nd == 9) f[n++] = cfg[5];
    else if (cfg[7]) begin
      case (cfg[6:5])
        2'b00: pb = ($countones(dm) % 2) == 0;
        2'b01: pb = ($countones(dm) % 2) == 1;
        2'b10: pb = 1'b1;
        default: pb = 1'b0;
      endcase
      f[n++] = pb;
    end
    f[n++] = 1'b1;
    exp_q.push_back(f); len_q.push_back(n); tag_q.push_back(tag);
  endtask

  task automatic send(input logic [7:0] cfg, input logic [7:0] d, input string tag);
    while (!tx_empty) @(negedge clk);
    reg_write(cfg);
    push_exp(cfg, d, tag);
    tx_write(d);
  endtask

  // monitor: decode line at mid-bit and compare to scoreboard
  bit mon_busy = 0;
  initial begin
    logic prev;
    logic [15:0] got, e;
    int n;
    string tg;
    prev = 1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !txd) begin
        mon_busy = 1;
        if (exp_q.size() == 0) begin
          chk(0, "R10 unexpected frame", 0, 1);
          n = 11; e = '1; tg = "none";
        end else begin
          e = exp_q.pop_front(); n = len_q.pop_front(); tg = tag_q.pop_front();
        end
        got = '1;
        repeat (15) @(negedge clk);
        got[0] = txd;
        for (int b = 1; b < n; b++) begin
          repeat (32) @(negedge clk);
          got[b] = txd;
        end
        chk(got == e, {tg, " R3 frame"}, int'(got), int'(e));
        mon_busy = 0;
      end
      prev = txd;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reg_rdata == 8'h01, "R1 reset reg", reg_rdata, 8'h01);
    chk(txd == 1'b1, "R1 reset txd", txd, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(txd == 1'b1, "R10 idle", txd, 1);

    reg_write(8'hFF);
    chk(reg_rdata == 8'hF9, "R2 readback, status bits ignore writes", reg_rdata, 8'hF9);
    err = 1; @(negedge clk);
    chk(reg_rdata == 8'hFD, "R2 err mirror", reg_rdata, 8'hFD);
    err = 0; rx_full = 1; @(negedge clk);
    chk(reg_rdata == 8'hFB, "R2 rx_full mirror", reg_rdata, 8'hFB);
    rx_full = 0;
    reg_write(8'h00);
    chk(reg_rdata == 8'h01, "R2 clear", reg_rdata, 8'h01);

    // R8: empty flag timing on idle shifter
    push_exp(8'h00, 8'hA5, "R4 8-bit");
    tx_write(8'hA5);
    chk(tx_empty == 1'b0, "R8 empty clears", tx_empty, 0);
    chk(reg_rdata[0] == 1'b0, "R8 reg bit0", reg_rdata[0], 0);
    @(negedge clk);
    chk(tx_empty == 1'b1, "R8 empty sets on load", tx_empty, 1);
    chk(txd == 1'b0, "R3 start bit", txd, 0);

    send(8'h08, 8'hC3, "R4 7-bit drops bit7");
    send(8'h18, 8'h3C, "R4 code 11 as 8-bit");
    send(8'h80, 8'h07, "R5 odd 8-bit");
    send(8'h80, 8'h03, "R5 odd 8-bit even ones");
    send(8'hA0, 8'h07, "R5 even 8-bit");
    send(8'h88, 8'hC1, "R5 odd 7-bit");
    send(8'hA8, 8'h81, "R5 even 7-bit");
    send(8'hC0, 8'h00, "R6 mark");
    send(8'hE8, 8'h7F, "R6 space");
    send(8'h30, 8'h5A, "R7 ninth=1");
    send(8'h10, 8'hA5, "R7 ninth=0");
    send(8'hF0, 8'h01, "R7 parity ignored");

    // R9: back to back
    send(8'h00, 8'h11, "R9 first");
    send(8'h00, 8'h22, "R9 second");
    chk(tx_empty == 1'b0, "R9 held while busy", tx_empty, 0);

    while (exp_q.size() != 0 || mon_busy) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(txd == 1'b1, "R10 idle after frames", txd, 1);
    chk(tx_empty == 1'b1, "R8 empty at end", tx_empty, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule